// File: doc/BRIEF.md
# Processing-System Power-Up Sequencer

This block brings up the supplies of a processing-system module in a fixed order and then releases the processor from power-on reset. It waits until the main 5 V input is reported stable and the carrier has released its active-low power-off request. It then starts a millisecond time base and enables the I/O supply as soon as processing-system power is reported stable. At a fixed delay from the power-off release it raises the full-power and low-power domain power-good outputs together. A second fixed delay after that, it lets the active-low processor reset go high.

After release, the carrier can pull the processor reset low through its own reset input. This holds off or restarts boot without dropping any enable or power-good, so the supplies are never sequenced a second time. If processing-system power is not reported inside the power-good window, the block latches a fault with every output low. Driving the power-off request low at any time returns the block to idle with every output low.

States: `ST_IDLE` (waiting for the start condition), `ST_SUPPLY_WAIT` (time base running, waiting for processing-system power), `ST_IO_ON` (I/O supply enabled, waiting for the power-good instant), `ST_DOM_GOOD` (domains good, counting the reset delay), `ST_RUN` (reset released), `ST_HOLD` (carrier holds reset, supplies kept) and `ST_FAULT` (latched failure). Transitions: IDLE→SUPPLY_WAIT on start; SUPPLY_WAIT→IO_ON on power stable; SUPPLY_WAIT→FAULT at the window end; IO_ON→DOM_GOOD at the window end; DOM_GOOD→RUN or DOM_GOOD→HOLD at the reset delay end, depending on the carrier reset; RUN→HOLD when the carrier reset goes low; HOLD→RUN when it goes high; any state→IDLE when the power-off request is low.

Top module: `pwr_up_seq`

## Requirements
- R1: The block stays idle, with all outputs low, until `main_ok` and `poff_req_n` are both sampled high at one clock edge. It leaves idle on that edge, called E0.
- R2: A prescaler held clear in idle produces a tick every `CLKS_PER_MS` cycles after E0. Every delay is an exact count of these ticks.
- R3: In `ST_SUPPLY_WAIT`, `io_en` goes high on the edge after `ps_pwr_ok` is first sampled high, provided that edge comes before the power-good instant.
- R4: `pg_full` and `pg_low` rise together exactly `PG_MS*CLKS_PER_MS` cycles after E0, always equal each other, and are never high while `io_en` is low.
- R5: `por_n` (1 = processor running, 0 = held in reset) rises exactly `POR_MS*CLKS_PER_MS` cycles after the power-good outputs rise, and is never high while `io_en` is low.
- R6: After release, `carrier_por_n` sampled low drives `por_n` low on the next edge while `io_en`, `pg_full` and `pg_low` stay high. `carrier_por_n` sampled high again drives `por_n` high on the next edge.
- R7: If `carrier_por_n` is low when the reset delay ends, `por_n` stays low with the supplies enabled until the carrier releases it.
- R8: If `ps_pwr_ok` has not been sampled high before the power-good instant (a sample on that very edge is late), the block enters a latched fault. All outputs stay low whatever `ps_pwr_ok` does, until `poff_req_n` is driven low.
- R9: `poff_req_n` sampled low in any state returns the block to idle, and all outputs are low after that edge.
- R10: While `rst_n` is low, the block is idle and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_ok | input | 1 | Main 5 V input reported stable |
| poff_req_n | input | 1 | Carrier power-off request, active low |
| ps_pwr_ok | input | 1 | Processing-system core and I/O power reported stable |
| carrier_por_n | input | 1 | Carrier-driven processor reset request, active low |
| io_en | output | 1 | Enable for the carrier's I/O-peripheral supplies |
| pg_full | output | 1 | Full-power domain power-good |
| pg_low | output | 1 | Low-power domain power-good (same value as pg_full) |
| por_n | output | 1 | Processor power-on reset, active low |

## Verification
The embedded properties assume that all inputs are synchronous to `clk` and are held steady across each edge. They also assume that `rst_n` is low from time zero until the first edges have passed. The bench therefore changes every input only on the falling clock edge, and it asserts reset at time zero. The properties also take the carrier reset to matter only once the domains are good. The stimulus moves `carrier_por_n` during idle and early sequencing as well as after release, and the ordering properties are stated so that they still hold in those cases.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SUPPLY_WAIT = 3'd1,
        ST_IO_ON       = 3'd2,
        ST_DOM_GOOD    = 3'd3,
        ST_RUN         = 3'd4,
        ST_HOLD        = 3'd5,
        ST_FAULT       = 3'd6
    } seq_state_t;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

    logic [CW-1:0] div_cnt;

    assign tick = !clr && (div_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (clr || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    generate
        if (CLKS_PER_MS > 1) begin : g_spacing
            // R2: consecutive ticks are never adjacent
            assert_tick_spacing_R2: assert property (
                @(posedge clk) disable iff (!rst_n) tick |=> !tick
            );
        end
    endgenerate

endmodule

// File: rtl/ms_timer.sv
module ms_timer #(
    parameter int MAX_MS = 50,
    localparam int TW = $clog2(MAX_MS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [TW-1:0] ms_cnt
);
    localparam logic [TW-1:0] CAP = TW'(MAX_MS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (clr) begin
            ms_cnt <= '0;
        end else if (tick && (ms_cnt != CAP)) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    // R4: the elapsed count never passes its ceiling
    assert_cnt_bound_R4: assert property (
        @(posedge clk) disable iff (!rst_n) ms_cnt <= CAP
    );

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import pwrseq_pkg::*;
#(
    parameter int PG_MS  = 50,
    parameter int POR_MS = 10,
    parameter int TW     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] ms_cnt,
    input  logic          main_ok,
    input  logic          poff_req_n,
    input  logic          ps_pwr_ok,
    input  logic          carrier_por_n,
    output logic          pre_clr,
    output logic          tmr_clr,
    output logic          io_en,
    output logic          pg,
    output logic          por_n
);
    localparam logic [TW-1:0] PG_LAST  = TW'(PG_MS - 1);
    localparam logic [TW-1:0] POR_LAST = TW'(POR_MS - 1);

    seq_state_t state, state_nx;
    logic pg_due, por_due;

    assign pg_due  = tick && (ms_cnt == PG_LAST);
    assign por_due = tick && (ms_cnt == POR_LAST);

    always_comb begin
        state_nx = state;
        if (!poff_req_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:        if (main_ok) state_nx = ST_SUPPLY_WAIT;
                ST_SUPPLY_WAIT: begin
                    if (pg_due)         state_nx = ST_FAULT;
                    else if (ps_pwr_ok) state_nx = ST_IO_ON;
                end
                ST_IO_ON:       if (pg_due) state_nx = ST_DOM_GOOD;
                ST_DOM_GOOD:    if (por_due)
                                    state_nx = carrier_por_n ? ST_RUN : ST_HOLD;
                ST_RUN:         if (!carrier_por_n) state_nx = ST_HOLD;
                ST_HOLD:        if (carrier_por_n)  state_nx = ST_RUN;
                ST_FAULT:       state_nx = ST_FAULT;
                default:        state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pre_clr = (state == ST_IDLE);
        tmr_clr = (state == ST_IDLE) ||
                  ((state_nx == ST_DOM_GOOD) && (state != ST_DOM_GOOD));
        io_en   = 1'b0;
        pg      = 1'b0;
        por_n   = 1'b0;
        unique case (state)
            ST_IO_ON:    io_en = 1'b1;
            ST_DOM_GOOD: begin io_en = 1'b1; pg = 1'b1; end
            ST_RUN:      begin io_en = 1'b1; pg = 1'b1; por_n = 1'b1; end
            ST_HOLD:     begin io_en = 1'b1; pg = 1'b1; end
            default:     ;
        endcase
    end

    // R1: no start without both start conditions
    assert_idle_gate_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(main_ok && poff_req_n)) |=> state == ST_IDLE
    );

    // R8: a fault is left only through the power-off request
    assert_fault_latch_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && poff_req_n) |=> state == ST_FAULT
    );

endmodule

// File: rtl/pwr_up_seq.sv
module pwr_up_seq #(
    parameter int CLKS_PER_MS = 100000,
    parameter int PG_MS       = 50,
    parameter int POR_MS      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_ok,
    input  logic poff_req_n,
    input  logic ps_pwr_ok,
    input  logic carrier_por_n,
    output logic io_en,
    output logic pg_full,
    output logic pg_low,
    output logic por_n
);
    localparam int MAX_MS = (PG_MS > POR_MS) ? PG_MS : POR_MS;
    localparam int TW     = $clog2(MAX_MS + 1);

    logic          tick, pre_clr, tmr_clr, pg;
    logic [TW-1:0] ms_cnt;

    ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .tick(tick)
    );

    ms_timer #(.MAX_MS(MAX_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .ms_cnt(ms_cnt)
    );

    seq_fsm #(.PG_MS(PG_MS), .POR_MS(POR_MS), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ms_cnt(ms_cnt),
        .main_ok(main_ok), .poff_req_n(poff_req_n), .ps_pwr_ok(ps_pwr_ok),
        .carrier_por_n(carrier_por_n), .pre_clr(pre_clr), .tmr_clr(tmr_clr),
        .io_en(io_en), .pg(pg), .por_n(por_n)
    );

    assign pg_full = pg;
    assign pg_low  = pg;

    // R4: domains are never good without the I/O supply
    assert_pg_needs_io_R4: assert property (
        @(posedge clk) disable iff (!rst_n) pg_full |-> io_en
    );

    // R5: reset never releases without the I/O supply
    assert_por_needs_io_R5: assert property (
        @(posedge clk) disable iff (!rst_n) por_n |-> io_en
    );

    // R6: carrier reset low forces the processor reset next cycle
    assert_carrier_holds_R6: assert property (
        @(posedge clk) disable iff (!rst_n) !carrier_por_n |=> !por_n
    );

    // R6: carrier reset never drops supplies
    assert_carrier_keeps_supply_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (pg_full && !carrier_por_n && poff_req_n) |=> (pg_full && io_en)
    );

    // R9: power-off request clears everything
    assert_poff_clears_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !poff_req_n |=> (!io_en && !pg_full && !pg_low && !por_n)
    );

endmodule

// File: tb/tb_pwr_up_seq.sv
module tb_pwr_up_seq;
    localparam int CLK_PERIOD = 10;
    localparam int C   = 4;
    localparam int PG  = 50;
    localparam int POR = 10;
    localparam int T_PG  = PG * C;
    localparam int T_POR = (PG + POR) * C;
    localparam int NVEC = 5;
    // {cycle index after E0 at which ps_pwr_ok is raised, fault expected}
    localparam int VEC [NVEC][2] = '{'{0, 0}, '{10, 0}, '{T_PG - 2, 0},
                                     '{T_PG - 1, 1}, '{400, 1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_ok = 1'b0, poff_req_n = 1'b0, ps_pwr_ok = 1'b0, carrier_por_n = 1'b1;
    logic io_en, pg_full, pg_low, por_n;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_up_seq #(.CLKS_PER_MS(C), .PG_MS(PG), .POR_MS(POR)) dut (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .poff_req_n(poff_req_n),
        .ps_pwr_ok(ps_pwr_ok), .carrier_por_n(carrier_por_n),
        .io_en(io_en), .pg_full(pg_full), .pg_low(pg_low), .por_n(por_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, io_en, pg_full, pg_low, por_n};
    endfunction

    task automatic power_off();
        @(negedge clk);
        poff_req_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 outputs low in power-off", outs(), 0);
    endtask

    // walks k = 0..n-1 negedges after E0, records first rise of each output
    task automatic watch(input int n, input int ok_at,
                         output int t_io, output int t_pg, output int t_por,
                         output int bad);
        t_io = -1; t_pg = -1; t_por = -1; bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (io_en && t_io < 0) t_io = k;
            if (pg_full && t_pg < 0) t_pg = k;
            if (por_n && t_por < 0) t_por = k;
            if (pg_full != pg_low) bad++;
            if (t_io >= 0 && !io_en) bad++;
            if (k == ok_at) ps_pwr_ok = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t_io, t_pg, t_por, bad;
        repeat (3) @(negedge clk);
        chk("R10 outputs low in reset", outs(), 0);
        rst_n = 1'b1;

        // vector table: supply-stable timing vs window end
        for (int v = 0; v < NVEC; v++) begin
            power_off();
            main_ok = 1'b1; ps_pwr_ok = 1'b0; carrier_por_n = 1'b1;
            poff_req_n = 1'b1;
            watch(T_POR + 20, VEC[v][0], t_io, t_pg, t_por, bad);
            chk("R4 pg equal and io_en steady", bad, 0);
            if (VEC[v][1] == 0) begin
                chk("R3 io_en rise cycle", t_io, VEC[v][0] + 1);
                chk("R2 R4 power-good cycle", t_pg, T_PG);
                chk("R5 reset release cycle", t_por, T_POR);
            end else begin
                chk("R8 io_en never in fault", t_io, -1);
                chk("R8 pg never in fault", t_pg, -1);
                ps_pwr_ok = 1'b1;
                repeat (300) @(negedge clk);
                chk("R8 fault latched", outs(), 0);
            end
        end

        // R6: carrier pulse after release, block ended vector table faulted
        power_off();
        ps_pwr_ok = 1'b1; poff_req_n = 1'b1;
        watch(T_POR + 4, 1000, t_io, t_pg, t_por, bad);
        chk("R5 released before carrier pulse", por_n, 1);
        carrier_por_n = 1'b0;
        @(negedge clk);
        chk("R6 carrier low holds reset, supplies kept", outs(), 4'b1110);
        repeat (20) @(negedge clk);
        chk("R6 hold keeps supplies", outs(), 4'b1110);
        carrier_por_n = 1'b1;
        @(negedge clk);
        chk("R6 carrier release restarts", outs(), 4'b1111);

        // R7: carrier holding reset at the release instant
        power_off();
        carrier_por_n = 1'b0; poff_req_n = 1'b1;
        watch(T_POR + 60, 1000, t_io, t_pg, t_por, bad);
        chk("R7 reset held by carrier", t_por, -1);
        chk("R7 supplies on while held", outs(), 4'b1110);
        carrier_por_n = 1'b1;
        @(negedge clk);
        chk("R7 release after carrier", por_n, 1);

        // R1: start blocked without main supply
        power_off();
        main_ok = 1'b0; poff_req_n = 1'b1;
        repeat (T_POR + 20) @(negedge clk);
        chk("R1 idle without main_ok", outs(), 0);
        main_ok = 1'b1;
        watch(T_POR + 4, 1000, t_io, t_pg, t_por, bad);
        chk("R1 io_en after main_ok", t_io, 1);
        chk("R1 pg timed from start", t_pg, T_PG);

        // R9: power-off during domain-good counting
        power_off();
        poff_req_n = 1'b1;
        watch(T_PG + 8, 1000, t_io, t_pg, t_por, bad);
        chk("R9 mid-sequence pg up", pg_full, 1);
        poff_req_n = 1'b0;
        @(negedge clk);
        chk("R9 power-off clears outputs", outs(), 0);

        // R10: reset during run
        poff_req_n = 1'b1;
        watch(T_POR + 4, 1000, t_io, t_pg, t_por, bad);
        chk("R5 run before reset", por_n, 1);
        rst_n = 1'b0;
        #1;
        chk("R10 reset clears outputs", outs(), 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule